// File: doc/BRIEF.md
# Ethernet PHY Basic Mode Control Register

This block holds the basic mode control word of a 10/100 Ethernet PHY and turns it into the controls for the port's data path. A simple register port takes the place of the serial management interface. It carries a one-cycle write strobe, a 16-bit write word, a combinational read word, and a strobe for each management clock (MDC) period. The management-side framer supplies two flags. One marks that preamble suppression is in force. The other marks the cycle in which a start field is seen.

The word controls a self-clearing soft reset with a completion timer, and a guard window after that reset. It also controls digital loopback of the MII transmit nibble stream into the receive stream, and manual or negotiated speed and duplex. Power-down blanks the data path. Isolate both blanks the data path and drops the output enables of the MII outputs. In every mode the register port keeps working. After power-down and isolate are both cleared, a ready timer holds the data path off for a set time.

Top module: `ephy_bmcr`

## Requirements
- R1: After hard reset the read word is 0x3000. Field positions are: bit 15 soft reset, bit 14 loopback, bit 13 speed (1 = 100 Mbps), bit 12 negotiation enable, bit 11 power-down, bit 10 isolate, bit 8 full duplex. All other bits read 0.
- R2: A write with bit 15 set, made while no soft reset is running, puts every field back to its reset value. Bit 15 then reads 1 for exactly RST_CYCLES cycles and clears itself.
- R3: Any write that arrives while bit 15 reads 1 is ignored, including another request for a soft reset.
- R4: Once a soft reset completes, a guard window stays open for GUARD_TICKS MDC strobes. While the window is open, a start field seen with preamble suppression active raises `st_err` for one cycle, on the following cycle. At any other time, or with suppression off, `st_err` stays 0.
- R5: With loopback set and the path active, the transmit enable, error and nibble reappear on `rx_dv`, `rx_er` and `rxd` exactly LB_DEPTH cycles later. `crs` follows the looped transmit enable. `col` stays 0, the medium transmit outputs stay 0, and the medium receive inputs are ignored.
- R6: With negotiation enable at 0, `link_speed100` equals bit 13 and `link_full` equals bit 8.
- R7: With negotiation enable at 1, the link outputs follow `an_speed100` and `an_full`. Bits 13 and 8 can still be written and read back.
- R8: With isolate set, every bit of `mii_oe` is 0. The bits, in order from bit 0, are TX_CLK, RX_CLK, RX_DV, RX_ER, RXD, COL and CRS. All data outputs read 0 and the transmit inputs have no effect.
- R9: With power-down set, every data output is 0 and `mii_oe` stays all ones. Register reads and writes still work, and the other fields keep their values.
- R10: When power-down and isolate are both 0 again, the data path stays off for READY_CYCLES cycles and then resumes.
- R11: In normal operation the transmit inputs pass to the medium transmit outputs, and the medium receive inputs pass to the MII receive outputs, with no added cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write word |
| reg_rdata | output | 16 | Register read word |
| mdc_tick | input | 1 | One strobe per management clock period |
| pre_sup | input | 1 | Preamble suppression active |
| st_seen | input | 1 | Start field detected this cycle |
| st_err | output | 1 | Start field inside the post-reset guard window |
| an_speed100 | input | 1 | Negotiated speed, 1 = 100 Mbps |
| an_full | input | 1 | Negotiated full duplex |
| link_speed100 | output | 1 | Speed in effect |
| link_full | output | 1 | Duplex in effect |
| tx_en | input | 1 | MII transmit enable |
| tx_er | input | 1 | MII transmit error |
| txd | input | DW | MII transmit nibble |
| med_tx_en | output | 1 | Transmit enable toward the medium side |
| med_tx_er | output | 1 | Transmit error toward the medium side |
| med_txd | output | DW | Transmit data toward the medium side |
| med_rx_dv | input | 1 | Receive valid from the medium side |
| med_rx_er | input | 1 | Receive error from the medium side |
| med_rxd | input | DW | Receive data from the medium side |
| med_col | input | 1 | Collision from the medium side |
| med_crs | input | 1 | Carrier sense from the medium side |
| rx_dv | output | 1 | MII receive valid |
| rx_er | output | 1 | MII receive error |
| rxd | output | DW | MII receive nibble |
| col | output | 1 | MII collision |
| crs | output | 1 | MII carrier sense |
| mii_oe | output | 7 | Output enables, bit order as in R8 |

## Verification
A wrong value in the stored control word shows up on the read word and the link or enable outputs in the same cycle it is stored. A soft reset counter that is off by one moves the cycle in which bit 15 falls, and it moves the start of the guard window with it. A fault in the ready timer or the active gate appears on the data outputs within one cycle of the expected edge. A fault in the loopback pipe appears as a nibble that arrives at the wrong cycle. The reference is compared against every port on every clock, so each of these faults is caught in the cycle where it first becomes visible.

// File: rtl/ephy_pkg.sv
package ephy_pkg;
   localparam int unsigned REG_W   = 16;
   localparam int unsigned B_RST   = 15;
   localparam int unsigned B_LOOP  = 14;
   localparam int unsigned B_SPD   = 13;
   localparam int unsigned B_ANE   = 12;
   localparam int unsigned B_PDN   = 11;
   localparam int unsigned B_ISO   = 10;
   localparam int unsigned B_DPX   = 8;
   localparam int unsigned OE_W    = 7;

   typedef struct packed {
      logic loop;
      logic spd;
      logic ane;
      logic pdn;
      logic iso;
      logic dpx;
   } ctl_t;

   localparam ctl_t CTL_DEFAULT = '{loop: 1'b0, spd: 1'b1, ane: 1'b1,
                                    pdn: 1'b0, iso: 1'b0, dpx: 1'b0};
endpackage

// File: rtl/ephy_ctl_regs.sv
module ephy_ctl_regs
   import ephy_pkg::*;
#(
   parameter int unsigned RST_CYCLES  = 32500,
   parameter int unsigned GUARD_TICKS = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [REG_W-1:0] wdata,
   input  logic             mdc_tick,
   input  logic             pre_sup,
   input  logic             st_seen,
   output ctl_t             ctl,
   output logic             busy,
   output logic [REG_W-1:0] rdata,
   output logic             st_err
);
   localparam int unsigned RCW = $clog2(RST_CYCLES + 1);
   localparam int unsigned GCW = $clog2(GUARD_TICKS + 1);

   initial begin
      assert (RST_CYCLES >= 1) else $error("RST_CYCLES must be at least 1");
      assert (GUARD_TICKS >= 1) else $error("GUARD_TICKS must be at least 1");
   end

   logic [RCW-1:0] rcnt;
   logic [GCW-1:0] gcnt;
   logic           guard;
   logic           done;

   assign done = busy && (rcnt == RCW'(RST_CYCLES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl  <= CTL_DEFAULT;
         busy <= 1'b0;
         rcnt <= '0;
      end else if (busy) begin
         if (done) busy <= 1'b0;
         rcnt <= rcnt + 1'b1;
      end else if (wr) begin
         if (wdata[B_RST]) begin
            ctl  <= CTL_DEFAULT;
            busy <= 1'b1;
            rcnt <= '0;
         end else begin
            ctl.loop <= wdata[B_LOOP];
            ctl.spd  <= wdata[B_SPD];
            ctl.ane  <= wdata[B_ANE];
            ctl.pdn  <= wdata[B_PDN];
            ctl.iso  <= wdata[B_ISO];
            ctl.dpx  <= wdata[B_DPX];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         guard  <= 1'b0;
         gcnt   <= '0;
         st_err <= 1'b0;
      end else begin
         st_err <= guard && pre_sup && st_seen;
         if (done) begin
            guard <= 1'b1;
            gcnt  <= '0;
         end else if (!busy && wr && wdata[B_RST]) begin
            guard <= 1'b0;
         end else if (guard && mdc_tick) begin
            if (gcnt == GCW'(GUARD_TICKS - 1)) guard <= 1'b0;
            gcnt <= gcnt + 1'b1;
         end
      end
   end

   always_comb begin
      rdata         = '0;
      rdata[B_RST]  = busy;
      rdata[B_LOOP] = ctl.loop;
      rdata[B_SPD]  = ctl.spd;
      rdata[B_ANE]  = ctl.ane;
      rdata[B_PDN]  = ctl.pdn;
      rdata[B_ISO]  = ctl.iso;
      rdata[B_DPX]  = ctl.dpx;
   end

   assert_defaults_on_rst_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (ctl == CTL_DEFAULT));
   assert_wr_ignored_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(ctl));
   assert_err_needs_presup_R4: assert property (@(posedge clk) disable iff (!rst_n)
      st_err |-> $past(pre_sup));
endmodule

// File: rtl/ephy_ready_timer.sv
module ephy_ready_timer #(
   parameter int unsigned READY_CYCLES = 12_500_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic quiet,
   output logic ready
);
   localparam int unsigned CW = $clog2(READY_CYCLES + 1);

   initial begin
      assert (READY_CYCLES >= 1) else $error("READY_CYCLES must be at least 1");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready <= 1'b1;
         cnt   <= '0;
      end else if (!quiet) begin
         ready <= 1'b0;
         cnt   <= '0;
      end else if (!ready) begin
         if (cnt == CW'(READY_CYCLES - 1)) ready <= 1'b1;
         cnt <= cnt + 1'b1;
      end
   end

   assert_ready_after_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> $past(quiet));
endmodule

// File: rtl/ephy_datapath.sv
module ephy_datapath
   import ephy_pkg::*;
#(
   parameter int unsigned DW       = 4,
   parameter int unsigned LB_DEPTH = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            active,
   input  logic            loop,
   input  logic            iso,
   input  logic            tx_en,
   input  logic            tx_er,
   input  logic [DW-1:0]   txd,
   output logic            med_tx_en,
   output logic            med_tx_er,
   output logic [DW-1:0]   med_txd,
   input  logic            med_rx_dv,
   input  logic            med_rx_er,
   input  logic [DW-1:0]   med_rxd,
   input  logic            med_col,
   input  logic            med_crs,
   output logic            rx_dv,
   output logic            rx_er,
   output logic [DW-1:0]   rxd,
   output logic            col,
   output logic            crs,
   output logic [OE_W-1:0] mii_oe
);
   localparam int unsigned SW = DW + 2;

   initial begin
      assert (LB_DEPTH >= 1) else $error("LB_DEPTH must be at least 1");
      assert (DW >= 1) else $error("DW must be at least 1");
   end

   logic [SW-1:0] stg [LB_DEPTH];
   logic [SW-1:0] stg_in;
   logic [SW-1:0] lb_out;

   assign stg_in = active ? {tx_en, tx_er, txd} : '0;
   assign lb_out = stg[LB_DEPTH-1];

   for (genvar g = 0; g < LB_DEPTH; g++) begin : g_pipe
      if (g == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= '0;
            else        stg[0] <= stg_in;
         end
      end else begin : g_body
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[g] <= '0;
            else        stg[g] <= stg[g-1];
         end
      end
   end

   always_comb begin
      med_tx_en = active && !loop && tx_en;
      med_tx_er = active && !loop && tx_er;
      med_txd   = (active && !loop) ? txd : '0;
      if (loop) begin
         rx_dv = active && lb_out[SW-1];
         rx_er = active && lb_out[SW-2];
         rxd   = active ? lb_out[DW-1:0] : '0;
         col   = 1'b0;
         crs   = active && lb_out[SW-1];
      end else begin
         rx_dv = active && med_rx_dv;
         rx_er = active && med_rx_er;
         rxd   = active ? med_rxd : '0;
         col   = active && med_col;
         crs   = active && med_crs;
      end
      mii_oe = iso ? '0 : '1;
   end

   assert_loop_no_medium_R5: assert property (@(posedge clk) disable iff (!rst_n)
      loop |-> (!med_tx_en && !col));
   assert_idle_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> (!rx_dv && !med_tx_en && !crs));
endmodule

// File: rtl/ephy_bmcr.sv
module ephy_bmcr
   import ephy_pkg::*;
#(
   parameter int unsigned DW           = 4,
   parameter int unsigned RST_CYCLES   = 32500,
   parameter int unsigned GUARD_TICKS  = 3,
   parameter int unsigned READY_CYCLES = 12_500_000,
   parameter int unsigned LB_DEPTH     = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            reg_wr,
   input  logic [15:0]     reg_wdata,
   output logic [15:0]     reg_rdata,
   input  logic            mdc_tick,
   input  logic            pre_sup,
   input  logic            st_seen,
   output logic            st_err,
   input  logic            an_speed100,
   input  logic            an_full,
   output logic            link_speed100,
   output logic            link_full,
   input  logic            tx_en,
   input  logic            tx_er,
   input  logic [DW-1:0]   txd,
   output logic            med_tx_en,
   output logic            med_tx_er,
   output logic [DW-1:0]   med_txd,
   input  logic            med_rx_dv,
   input  logic            med_rx_er,
   input  logic [DW-1:0]   med_rxd,
   input  logic            med_col,
   input  logic            med_crs,
   output logic            rx_dv,
   output logic            rx_er,
   output logic [DW-1:0]   rxd,
   output logic            col,
   output logic            crs,
   output logic [6:0]      mii_oe
);
   ctl_t ctl;
   logic busy;
   logic ready;
   logic active;

   ephy_ctl_regs #(.RST_CYCLES(RST_CYCLES), .GUARD_TICKS(GUARD_TICKS)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata),
      .mdc_tick(mdc_tick), .pre_sup(pre_sup), .st_seen(st_seen),
      .ctl(ctl), .busy(busy), .rdata(reg_rdata), .st_err(st_err)
   );

   ephy_ready_timer #(.READY_CYCLES(READY_CYCLES)) u_ready (
      .clk(clk), .rst_n(rst_n), .quiet(!ctl.pdn && !ctl.iso), .ready(ready)
   );

   assign active        = ready && !ctl.pdn && !ctl.iso;
   assign link_speed100 = ctl.ane ? an_speed100 : ctl.spd;
   assign link_full     = ctl.ane ? an_full : ctl.dpx;

   ephy_datapath #(.DW(DW), .LB_DEPTH(LB_DEPTH)) u_dp (
      .clk(clk), .rst_n(rst_n), .active(active), .loop(ctl.loop), .iso(ctl.iso),
      .tx_en(tx_en), .tx_er(tx_er), .txd(txd),
      .med_tx_en(med_tx_en), .med_tx_er(med_tx_er), .med_txd(med_txd),
      .med_rx_dv(med_rx_dv), .med_rx_er(med_rx_er), .med_rxd(med_rxd),
      .med_col(med_col), .med_crs(med_crs),
      .rx_dv(rx_dv), .rx_er(rx_er), .rxd(rxd), .col(col), .crs(crs),
      .mii_oe(mii_oe)
   );
endmodule

// File: tb/tb_ephy_bmcr.sv
`timescale 1ns/1ps
module tb_ephy_bmcr;
   localparam int DW = 4, RSTC = 20, GT = 3, RDY = 10, LBD = 3;

   logic clk = 0, rst_n = 0;
   logic reg_wr = 0; logic [15:0] reg_wdata = 0; logic [15:0] reg_rdata;
   logic mdc_tick = 0, pre_sup = 0, st_seen = 0, st_err;
   logic an_speed100 = 0, an_full = 0, link_speed100, link_full;
   logic tx_en = 0, tx_er = 0; logic [DW-1:0] txd = 0;
   logic med_tx_en, med_tx_er; logic [DW-1:0] med_txd;
   logic med_rx_dv = 0, med_rx_er = 0, med_col = 0, med_crs = 0;
   logic [DW-1:0] med_rxd = 0;
   logic rx_dv, rx_er, col, crs; logic [DW-1:0] rxd; logic [6:0] mii_oe;

   always #2 clk = ~clk;

   ephy_bmcr #(.DW(DW), .RST_CYCLES(RSTC), .GUARD_TICKS(GT),
               .READY_CYCLES(RDY), .LB_DEPTH(LBD)) dut (.*);

   int vecs = 0, errs = 0, st_hits = 0, cyc = 0;
   bit st_on = 0;

   // behavioural reference state
   bit m_loop, m_spd, m_ane, m_pdn, m_iso, m_dpx, m_busy, m_guard, m_err, m_ready;
   int m_rcnt, m_gcnt, m_rdycnt;
   logic [DW+1:0] hist[$];

   task automatic model_reset();
      m_loop = 0; m_spd = 1; m_ane = 1; m_pdn = 0; m_iso = 0; m_dpx = 0;
      m_busy = 0; m_guard = 0; m_err = 0; m_ready = 1;
      m_rcnt = 0; m_gcnt = 0; m_rdycnt = 0;
      hist = {};
      for (int i = 0; i < LBD; i++) hist.push_back('0);
   endtask

   function automatic bit m_act();
      return m_ready && !m_pdn && !m_iso;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) model_reset();
      else begin
         bit act, quiet, fin, nerr;
         act = m_act(); quiet = !m_pdn && !m_iso;
         hist.push_front(act ? {tx_en, tx_er, txd} : '0);
         void'(hist.pop_back());
         nerr = m_guard && pre_sup && st_seen;
         fin = m_busy && (m_rcnt == RSTC - 1);
         if (fin) begin m_guard = 1; m_gcnt = 0; end
         else if (!m_busy && reg_wr && reg_wdata[15]) m_guard = 0;
         else if (m_guard && mdc_tick) begin
            if (m_gcnt == GT - 1) m_guard = 0;
            m_gcnt++;
         end
         m_err = nerr;
         if (!quiet) begin m_ready = 0; m_rdycnt = 0; end
         else if (!m_ready) begin
            if (m_rdycnt == RDY - 1) m_ready = 1;
            m_rdycnt++;
         end
         if (m_busy) begin
            if (fin) m_busy = 0;
            m_rcnt++;
         end else if (reg_wr) begin
            if (reg_wdata[15]) begin
               m_loop = 0; m_spd = 1; m_ane = 1; m_pdn = 0; m_iso = 0; m_dpx = 0;
               m_busy = 1; m_rcnt = 0;
            end else begin
               m_loop = reg_wdata[14]; m_spd = reg_wdata[13]; m_ane = reg_wdata[12];
               m_pdn = reg_wdata[11]; m_iso = reg_wdata[10]; m_dpx = reg_wdata[8];
            end
         end
      end
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      if (act !== exp) begin
         errs++;
         $display("FAIL %s cycle %0d: actual %h expected %h", tag, cyc, act, exp);
      end
   endtask

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         bit a; logic [DW+1:0] lb;
         logic [15:0] e_rd;
         a = m_act(); lb = hist[LBD-1];
         e_rd = '0;
         e_rd[15] = m_busy; e_rd[14] = m_loop; e_rd[13] = m_spd; e_rd[12] = m_ane;
         e_rd[11] = m_pdn; e_rd[10] = m_iso; e_rd[8] = m_dpx;
         vecs++;
         chk("R1 R2 R3 R9 rdata", 32'(reg_rdata), 32'(e_rd));
         chk("R4 st_err", 32'(st_err), 32'(m_err));
         chk("R6 R7 link", 32'({link_speed100, link_full}),
             32'({m_ane ? an_speed100 : m_spd, m_ane ? an_full : m_dpx}));
         chk("R8 oe", 32'(mii_oe), m_iso ? 32'h0 : 32'h7F);
         chk("R5 R8 R9 R11 medium tx", 32'({med_tx_en, med_tx_er, med_txd}),
             (a && !m_loop) ? 32'({tx_en, tx_er, txd}) : 32'h0);
         chk("R5 R9 R10 R11 rx path", 32'({rx_dv, rx_er, rxd, col, crs}),
             !a ? 32'h0 :
             m_loop ? 32'({lb[DW+1], lb[DW], lb[DW-1:0], 1'b0, lb[DW+1]}) :
                      32'({med_rx_dv, med_rx_er, med_rxd, med_col, med_crs}));
         if (st_err) st_hits++;
      end
   end

   task automatic step(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); #1;
         reg_wr = 0;
         {tx_en, tx_er, txd} = ($urandom & 6'h3F);
         {med_rx_dv, med_rx_er, med_rxd, med_col, med_crs} = ($urandom & 8'hFF);
         {an_speed100, an_full} = ($urandom & 2'h3);
         mdc_tick = (cyc % 4 == 0);
         st_seen = st_on && ($urandom % 3 == 0);
      end
   endtask

   task automatic wr(logic [15:0] v);
      @(negedge clk); #1;
      reg_wr = 1; reg_wdata = v;
      @(negedge clk); #1;
      reg_wr = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1 rst_n = 1;
      step(5);                 // R1 reset word, R11 pass-through
      step(20);
      wr(16'h0100); step(10);  // R6 manual 10 Mbps full duplex
      wr(16'h2000); step(5);
      wr(16'h1100); step(10);  // R7 negotiated, bit 8 reads back
      wr(16'h4000); step(25);  // R5 loopback
      wr(16'h4400); step(8);   // R8 isolate during loopback
      wr(16'h0000); step(15);  // R10 ready delay
      wr(16'h0800); step(10);  // R9 power-down
      wr(16'h0900); step(4);   // R9 writes still accepted
      wr(16'h0000); step(15);
      wr(16'h4900);            // R2 soft reset from non-default state
      pre_sup = 1; st_on = 1;
      wr(16'h8000);
      wr(16'h4000);            // R3 ignored while busy
      wr(16'h8000);            // R3 second request ignored
      step(RSTC + 20);         // R4 guard window after completion
      st_on = 1; pre_sup = 0;
      wr(16'h8000); step(RSTC + 20);  // R4 suppression off: no error
      // R4 the window must have produced at least one error pulse
      vecs++;
      if (st_hits == 0) begin
         errs++;
         $display("FAIL R4 guard hits: actual %0d expected >0", st_hits);
      end
      st_on = 0;
      step(10);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end
endmodule